// File: doc/BRIEF.md
# Parallel-Capture Serial Readout Register

This block captures the logic states of a group of digital field inputs and returns them to a host one bit at a time over a three-wire serial link. The host holds the load strobe low to take a snapshot of the inputs. It then releases the strobe, enables the serial clock, and reads the bits in ascending input order. Bits enter the register on rising serial-clock edges. A separate output stage updates on falling edges, so downstream logic can sample the output safely on the next rising edge.

Any number of units can be chained by wiring each output to the next unit's serial input. The host interface stays the same: it only needs more clock cycles. The serial clock, the strobe and the enable are sampled on the block's system clock `clk`. An edge on the serial clock is acted on at the `clk` edge where the new level is first seen.

The block keeps a hardware quirk. If the enable is asserted while the serial clock is high, the first enabled edge is a falling one. In that case the first bit is presented early, one leftover bit from before the load is inserted, and the readout needs one extra falling edge to reach the last input.

Top module: `piso_capture`

## Requirements
- R1: While `ld_n` is low at a `clk` edge, the register takes `par_in`, and `sop` shows `par_in[0]` after that same edge; serial-clock edges are ignored during the load.
- R2: While `ld_n` is high, changes on `par_in` do not alter the bits that are later shifted out.
- R3: While `ce_n` is high, `sclk` edges are ignored and `sop` holds its value.
- R4: An enabled rising `sclk` edge moves every stage one place toward the output and takes `sip` into the far end.
- R5: An enabled falling `sclk` edge copies the stage nearest the output onto `sop`; `sop` changes at no other time except during load or reset.
- R6: After a load, the bits are read before each rising edge in the order `par_in[0]`, `par_in[1]`, …, `par_in[7]`. The `sip` value taken on the first rising edge appears on `sop` after the eighth falling edge.
- R7: If the first enabled edge after a load is falling, `sop` still shows `par_in[0]`. After the next rise and fall it shows the value that the second stage from the output held just before the load began. The following falls show `par_in[1]` through `par_in[7]`, so `par_in[7]` appears only on the ninth enabled falling edge. The `sip` value taken on that first rise is discarded.
- R8: With two units chained (upstream `sop` to downstream `sip`) and the enable asserted while `sclk` is low, sixteen reads return all eight downstream inputs in ascending order, followed by all eight upstream inputs.
- R9: An asynchronous low on `rst_n` clears every stage and `sop` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low load strobe (level sensitive) |
| ce_n | input | 1 | Active-low serial clock enable |
| sclk | input | 1 | Serial clock from the host |
| sip | input | 1 | Serial data in, from the previous unit in a chain |
| par_in | input | WIDTH | Parallel input states, bit 0 read first |
| sop | output | 1 | Serial data out |

## Verification
Every result is due one `clk` edge after the input change is first sampled. A load shows `par_in[0]` on `sop` after that edge. A falling `sclk` updates `sop` after the `clk` edge that first sees the low level. A rising edge shifts the hidden stages, which become visible only after the next fall. The bench drives inputs on falling `clk` edges and holds each `sclk` level for three `clk` cycles. It samples `sop` on falling `clk` edges, either just before raising `sclk` or after each fall has settled. A behavioural queue model of both chained units is stepped on every rising `clk` edge and compared with both outputs at every falling edge.

// File: rtl/piso_capture.sv
module piso_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic             ce_n,
  input  logic             sclk,
  input  logic             sip,
  input  logic [WIDTH-1:0] par_in,
  output logic             sop
);

  logic [WIDTH-1:0] stage_q;
  logic out_q, sclk_q, ld_q, armed_q, skew_q, stale_q;
  logic rise_ev, fall_ev;

  assign rise_ev = ld_n & ~ce_n & sclk & ~sclk_q;
  assign fall_ev = ld_n & ~ce_n & ~sclk & sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= 1'b0;
      sclk_q  <= 1'b0;
      ld_q    <= 1'b1;
      armed_q <= 1'b0;
      skew_q  <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      ld_q   <= ld_n;
      if (!ld_n) begin
        if (ld_q) stale_q <= stage_q[1];
        stage_q <= par_in;
        out_q   <= par_in[0];
        armed_q <= 1'b1;
        skew_q  <= 1'b0;
      end else if (rise_ev) begin
        armed_q <= 1'b0;
        if (armed_q && skew_q) stage_q[0] <= stale_q;
        else stage_q <= {sip, stage_q[WIDTH-1:1]};
      end else if (fall_ev) begin
        out_q <= stage_q[0];
        if (armed_q) skew_q <= 1'b1;
      end
    end
  end

  assign sop = out_q;

endmodule

// File: rtl/piso_capture_chk.sv
module piso_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_n,
  input logic ce_n,
  input logic sclk,
  input logic sclk_q,
  input logic par0,
  input logic sop
);

  assert_load_shows_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> sop == $past(par0));

  assert_disabled_clock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n && ce_n |=> $stable(sop));

  assert_output_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n && !(!ce_n && sclk_q && !sclk) |=> $stable(sop));

  assert_reset_clears_R9: assert property (@(posedge clk)
    !rst_n |-> sop == 1'b0);

endmodule

bind piso_capture piso_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ce_n(ce_n),
  .sclk(sclk), .sclk_q(sclk_q), .par0(par_in[0]), .sop(sop)
);

// File: tb/tb_piso_capture.sv
module tb_piso_capture;
  localparam int CLK_PERIOD = 10;
  localparam int H = 3;

  logic clk = 1'b0, rst_n = 1'b1;
  logic ld_n = 1'b1, ce_n = 1'b1, sclk = 1'b0, sip_in = 1'b0;
  logic [7:0] par_a = '0, par_b = '0;
  logic link, sop_b;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  piso_capture #(.WIDTH(8)) u_up (.clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ce_n(ce_n),
    .sclk(sclk), .sip(sip_in), .par_in(par_a), .sop(link));
  piso_capture #(.WIDTH(8)) dut (.clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ce_n(ce_n),
    .sclk(sclk), .sip(link), .par_in(par_b), .sop(sop_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: one queue per unit, head first
  bit mq [2][$];
  bit mo [2];
  bit marm [2];
  bit mskw [2];
  bit mstl [2];
  bit mscl, mld;

  always @(posedge clk or negedge rst_n) begin
    bit rise, fall, o_up, sin;
    if (!rst_n) begin
      for (int u = 0; u < 2; u++) begin
        mq[u].delete();
        for (int i = 0; i < 8; i++) mq[u].push_back(1'b0);
        mo[u] = 0; marm[u] = 0; mskw[u] = 0; mstl[u] = 0;
      end
      mscl = 0; mld = 1;
    end else begin
      rise = ld_n && !ce_n && sclk && !mscl;
      fall = ld_n && !ce_n && !sclk && mscl;
      o_up = mo[0];
      for (int u = 0; u < 2; u++) begin
        sin = (u == 0) ? sip_in : o_up;
        if (!ld_n) begin
          if (mld) mstl[u] = mq[u][1];
          mq[u].delete();
          for (int i = 0; i < 8; i++) mq[u].push_back(u == 0 ? par_a[i] : par_b[i]);
          mo[u] = mq[u][0]; marm[u] = 1; mskw[u] = 0;
        end else if (rise) begin
          if (marm[u] && mskw[u]) mq[u][0] = mstl[u];
          else begin
            void'(mq[u].pop_front());
            mq[u].push_back(sin);
          end
          marm[u] = 0;
        end else if (fall) begin
          mo[u] = mq[u][0];
          if (marm[u]) mskw[u] = 1;
        end
      end
      mscl = sclk; mld = ld_n;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 model compare upstream", link, mo[0]);
    chk("R5 model compare downstream", sop_b, mo[1]);
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; wait_n(H);
    sclk = 1'b0; wait_n(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] exp_a, exp_b, pat;
    logic hold_a, hold_b;
    #1 rst_n = 1'b0;
    wait_n(3);
    chk("R9 reset downstream", sop_b, 1'b0);
    chk("R9 reset upstream", link, 1'b0);
    rst_n = 1'b1;
    wait_n(2);

    // load and cascaded readout
    exp_a = 8'hA5; exp_b = 8'h3C;
    par_a = exp_a; par_b = exp_b;
    ld_n = 1'b0; wait_n(2);
    chk("R1 load downstream first bit", sop_b, exp_b[0]);
    chk("R1 load upstream first bit", link, exp_a[0]);
    ld_n = 1'b1; wait_n(1);
    par_a = 8'h0F; par_b = 8'hF0;
    ce_n = 1'b0; wait_n(H);
    for (int k = 0; k < 16; k++) begin
      if (k < 8) chk("R6 R2 downstream order", sop_b, exp_b[k]);
      else chk("R8 R2 cascaded upstream bit", sop_b, exp_a[k-8]);
      if (k == 8) chk("R4 R6 sip reaches upstream output", link, 1'b1);
      sip_in = (k == 0);
      sclk_pulse();
    end
    sip_in = 1'b0;

    // disabled clock
    ce_n = 1'b1; wait_n(1);
    hold_a = link; hold_b = sop_b;
    for (int k = 0; k < 3; k++) sclk_pulse();
    chk("R3 disabled clock downstream", sop_b, hold_b);
    chk("R3 disabled clock upstream", link, hold_a);

    // badly timed enable
    rst_n = 1'b0; wait_n(1);
    chk("R9 reset mid run", sop_b, 1'b0);
    rst_n = 1'b1; wait_n(1);
    pat = 8'b0100_1101;
    ce_n = 1'b0; wait_n(H);
    for (int k = 0; k < 8; k++) begin
      sip_in = pat[k];
      sclk_pulse();
    end
    sip_in = 1'b1;
    ce_n = 1'b1;
    exp_a = 8'b1100_0110; par_a = exp_a; par_b = 8'h5A;
    ld_n = 1'b0; wait_n(2);
    ld_n = 1'b1; wait_n(1);
    sclk = 1'b1; wait_n(H);
    ce_n = 1'b0; wait_n(H);
    sclk = 1'b0; wait_n(H);
    chk("R7 early first bit", link, exp_a[0]);
    for (int k = 1; k <= 8; k++) begin
      sclk_pulse();
      if (k == 1) chk("R7 stale bit", link, pat[1]);
      else chk("R7 shifted bit after stale", link, exp_a[k-1]);
    end
    ce_n = 1'b1; wait_n(2);

    // asynchronous clear between clock edges
    chk("R9 precondition nonzero", link, 1'b1);
    #2 rst_n = 1'b0;
    #1 chk("R9 async clear", link, 1'b0);
    chk("R9 async clear downstream", sop_b, 1'b0);
    done = 1;
    wait_n(1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule